// File: doc/BRIEF.md
# Pin-Level I/O Port with Interrupt Detection

This block is a bank of up to 32 general-purpose pins behind a small APB-style register bus. Software drives an output value and an output-enable for each pin, and reads back the pin levels after they have passed through a two-flop synchronizer. A pin that is configured as an input can also raise an interrupt request.

Each pin's trigger is set by two independent bits. One bit picks level or edge sensitivity. The other bit picks the polarity: active-high or rising, versus active-low or falling. Level requests follow the synchronized pin directly. Edge requests are caught in a sticky bit, which holds until software writes a one to that pin's bit in the end-of-interrupt register.

Raw status is gated by a per-pin enable. Masked status is the raw status with the mask bits removed. The OR of all masked bits drives the single interrupt line. Software reads the masked status and services the highest set bit first.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, the data, direction, enable, mask, type, polarity and debounce registers read 0, as do both status registers; `pin_out`, `pin_oe` and `irq` are 0.
- R2: A write to offset 0x00 sets `pin_out`. A write to offset 0x04 sets `pin_oe`, where a 1 bit makes the pin an output. Both registers read back what was written.
- R3: A read at offset 0x50 returns the pin levels as they were two rising clock edges earlier.
- R4: A pin whose type bit (offset 0x38) is 0 is level-sensitive. Its raw status bit (offset 0x44) is 1 while the synchronized pin matches its polarity bit (offset 0x3C), where 1 is active-high and 0 is active-low. The bit returns to 0 when the level goes inactive.
- R5: A pin whose type bit is 1 is edge-sensitive. Its raw status bit sets on a rising edge when its polarity bit is 1, and on a falling edge when its polarity bit is 0. The opposite edge never sets it. Once set, the bit stays set after the pin returns to its old level.
- R6: Writing 1 to a bit at offset 0x4C clears that pin's latched edge status. Writing 0 leaves the status unchanged. Reads of offset 0x4C return 0.
- R7: A pin whose enable bit (offset 0x30) is 0 shows no raw or masked status. An edge that occurs while the pin is disabled is not latched.
- R8: The masked status at offset 0x40 equals raw AND NOT mask, where the mask is at offset 0x34. `irq` is 1 exactly when any masked status bit is 1.
- R9: A pin whose direction bit is 1 (output) never produces interrupt status.
- R10: Writes to offsets 0x40, 0x44 and 0x50 have no effect. Offset 0x48 is a stub debounce register that reads back what was written. Offset 0x60 keeps only bit 0 of the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address; low 8 bits decoded |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pin_in | input | NPINS | Asynchronous pin levels |
| pin_out | output | NPINS | Output data to pads |
| pin_oe | output | NPINS | Output enable to pads |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench checks three edge-mode corner cases:
- The edge opposite to the selected polarity must not latch. A design that detected any change would set status on a falling edge for a rising-edge pin.
- An edge that arrives while the pin is disabled must be lost. A design that latched before gating by the enable would raise a stale interrupt the moment the pin is enabled.
- Writing zeros to the end-of-interrupt register must keep pending bits. A design that cleared the whole register on any write would drop requests.

The bench also checks that an output pin stays silent even when it is enabled, that masking removes a pin from `irq` while its raw bit stays visible, and that writes to the status and pin-read offsets change nothing.

// File: rtl/gpio_irq_pkg.sv
// Package: register offsets and address decode shared by the I/O port.
// Assumes the bus offsets fit in 8 bits; upper address bits are not decoded.
package gpio_irq_pkg;

    localparam logic [7:0] OFF_DOUT   = 8'h00;
    localparam logic [7:0] OFF_DIR    = 8'h04;
    localparam logic [7:0] OFF_INTEN  = 8'h30;
    localparam logic [7:0] OFF_MASK   = 8'h34;
    localparam logic [7:0] OFF_TYPE   = 8'h38;
    localparam logic [7:0] OFF_POL    = 8'h3C;
    localparam logic [7:0] OFF_STAT   = 8'h40;
    localparam logic [7:0] OFF_RAW    = 8'h44;
    localparam logic [7:0] OFF_DEBNC  = 8'h48;
    localparam logic [7:0] OFF_EOI    = 8'h4C;
    localparam logic [7:0] OFF_EXT    = 8'h50;
    localparam logic [7:0] OFF_LSYNC  = 8'h60;

    typedef enum logic [3:0] {
        SEL_DOUT, SEL_DIR, SEL_INTEN, SEL_MASK, SEL_TYPE, SEL_POL,
        SEL_STAT, SEL_RAW, SEL_DEBNC, SEL_EOI, SEL_EXT, SEL_LSYNC, SEL_NONE
    } reg_sel_e;

    // Map a byte offset to a register selector.
    function automatic reg_sel_e decode_off(input logic [7:0] off);
        case (off)
            OFF_DOUT:  return SEL_DOUT;
            OFF_DIR:   return SEL_DIR;
            OFF_INTEN: return SEL_INTEN;
            OFF_MASK:  return SEL_MASK;
            OFF_TYPE:  return SEL_TYPE;
            OFF_POL:   return SEL_POL;
            OFF_STAT:  return SEL_STAT;
            OFF_RAW:   return SEL_RAW;
            OFF_DEBNC: return SEL_DEBNC;
            OFF_EOI:   return SEL_EOI;
            OFF_EXT:   return SEL_EXT;
            OFF_LSYNC: return SEL_LSYNC;
            default:   return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
// Two-flop synchronizer, one chain per pin.
// Assumes pin inputs are asynchronous to clk; output lags input by two edges.
module gpio_irq_sync #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_lvl
);

    for (genvar i = 0; i < NPINS; i++) begin : g_chain
        logic stage1, stage2;

        // Two-stage capture of one pin into the clock domain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage1 <= 1'b0;
                stage2 <= 1'b0;
            end else begin
                stage1 <= pin_in[i];
                stage2 <= stage1;
            end
        end

        assign pin_lvl[i] = stage2;
    end

endmodule

// File: rtl/gpio_irq_detect.sv
// Interrupt detection: level/edge with polarity, sticky edge latch, masking.
// Assumes pin_lvl is already synchronized; eoi_clr is a one-cycle pulse.
module gpio_irq_detect #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_lvl,
    input  logic [NPINS-1:0] dir,
    input  logic [NPINS-1:0] inten,
    input  logic [NPINS-1:0] imask,
    input  logic [NPINS-1:0] itype,
    input  logic [NPINS-1:0] ipol,
    input  logic [NPINS-1:0] eoi_clr,
    output logic [NPINS-1:0] raw_stat,
    output logic [NPINS-1:0] mask_stat
);

    logic [NPINS-1:0] prev;
    logic [NPINS-1:0] sticky;
    logic [NPINS-1:0] armed;
    logic [NPINS-1:0] rise, fall, hit_edge, set_ev, lvl_act;

    always_comb begin
        armed    = inten & ~dir;
        rise     = pin_lvl & ~prev;
        fall     = ~pin_lvl & prev;
        hit_edge = (ipol & rise) | (~ipol & fall);
        set_ev   = armed & itype & hit_edge;
        lvl_act  = ~(pin_lvl ^ ipol);
    end

    // Hold the previous synchronized level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= pin_lvl;
    end

    // Sticky edge latch: cleared by end-of-interrupt, a new edge wins.
    always_ff @(posedge clk) begin
        if (!rst_n) sticky <= '0;
        else        sticky <= (sticky & ~eoi_clr) | set_ev;
    end

    assign raw_stat  = armed & ((~itype & lvl_act) | (itype & sticky));
    assign mask_stat = raw_stat & ~imask;

    p_sticky_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(sticky) & ~$past(eoi_clr) & ~sticky) == '0));

    p_eoi_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((eoi_clr & ~set_ev) != '0) |=> ((sticky & $past(eoi_clr & ~set_ev)) == '0));

    p_edge_needs_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sticky & ~$past(sticky) & ~($past(pin_lvl) ^ $past(prev))) == '0));

    p_enable_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sticky & ~$past(sticky) & ~$past(inten)) == '0));

endmodule

// File: rtl/gpio_irq_regs.sv
// Register file and bus decode for the I/O port.
// Assumes ADDR_W >= 8, NPINS <= 32; writes commit in the access phase.
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    input  logic [NPINS-1:0]  raw_stat,
    input  logic [NPINS-1:0]  mask_stat,
    input  logic [NPINS-1:0]  pin_lvl,
    output logic [NPINS-1:0]  dout,
    output logic [NPINS-1:0]  dir,
    output logic [NPINS-1:0]  inten,
    output logic [NPINS-1:0]  imask,
    output logic [NPINS-1:0]  itype,
    output logic [NPINS-1:0]  ipol,
    output logic [NPINS-1:0]  eoi_clr
);

    logic [NPINS-1:0] debnc;
    logic             lsync;
    logic             wr_en;
    logic [NPINS-1:0] wdat;
    reg_sel_e         sel;

    assign sel   = decode_off(paddr[7:0]);
    assign wr_en = psel & penable & pwrite;
    assign wdat  = pwdata[NPINS-1:0];

    // Configuration registers updated by bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout  <= '0;
            dir   <= '0;
            inten <= '0;
            imask <= '0;
            itype <= '0;
            ipol  <= '0;
            debnc <= '0;
            lsync <= 1'b0;
        end else if (wr_en) begin
            case (sel)
                SEL_DOUT:  dout  <= wdat;
                SEL_DIR:   dir   <= wdat;
                SEL_INTEN: inten <= wdat;
                SEL_MASK:  imask <= wdat;
                SEL_TYPE:  itype <= wdat;
                SEL_POL:   ipol  <= wdat;
                SEL_DEBNC: debnc <= wdat;
                SEL_LSYNC: lsync <= pwdata[0];
                default:   ;
            endcase
        end
    end

    // One-cycle clear pulse for latched edges.
    assign eoi_clr = (wr_en && sel == SEL_EOI) ? wdat : '0;

    // Read multiplexer, valid while the bus selects the block.
    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            case (sel)
                SEL_DOUT:  prdata = 32'(dout);
                SEL_DIR:   prdata = 32'(dir);
                SEL_INTEN: prdata = 32'(inten);
                SEL_MASK:  prdata = 32'(imask);
                SEL_TYPE:  prdata = 32'(itype);
                SEL_POL:   prdata = 32'(ipol);
                SEL_STAT:  prdata = 32'(mask_stat);
                SEL_RAW:   prdata = 32'(raw_stat);
                SEL_DEBNC: prdata = 32'(debnc);
                SEL_EXT:   prdata = 32'(pin_lvl);
                SEL_LSYNC: prdata = {31'd0, lsync};
                default:   prdata = '0;
            endcase
        end
    end

    p_cfg_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(dout) && $stable(dir) && $stable(inten)));

    p_eoi_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !pwrite && paddr[7:0] == OFF_EOI) |-> (prdata == '0));

endmodule

// File: rtl/gpio_irq_port.sv
// Top: I/O port with per-pin interrupt detection and one combined request.
// Assumes a single clock domain for the bus; pins are asynchronous.
module gpio_irq_port #(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);

    logic [NPINS-1:0] pin_lvl, raw_stat, mask_stat;
    logic [NPINS-1:0] dout, dir, inten, imask, itype, ipol, eoi_clr;

    gpio_irq_sync #(.NPINS(NPINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_lvl(pin_lvl)
    );

    gpio_irq_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .raw_stat(raw_stat), .mask_stat(mask_stat), .pin_lvl(pin_lvl),
        .dout(dout), .dir(dir), .inten(inten), .imask(imask),
        .itype(itype), .ipol(ipol), .eoi_clr(eoi_clr)
    );

    gpio_irq_detect #(.NPINS(NPINS)) u_detect (
        .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .dir(dir),
        .inten(inten), .imask(imask), .itype(itype), .ipol(ipol),
        .eoi_clr(eoi_clr), .raw_stat(raw_stat), .mask_stat(mask_stat)
    );

    assign pin_out = dout;
    assign pin_oe  = dir;
    assign irq     = |mask_stat;

    p_mask_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw_stat & ~imask) == '0) |-> !irq);

    p_out_pin_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ((mask_stat & ~pin_oe) != '0));

endmodule

// File: tb/gpio_irq_port_test.sv
module gpio_irq_port_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_DOUT = 8'h00, A_DIR = 8'h04, A_INTEN = 8'h30,
        A_MASK = 8'h34, A_TYPE = 8'h38, A_POL = 8'h3C, A_STAT = 8'h40,
        A_RAW = 8'h44, A_DEBNC = 8'h48, A_EOI = 8'h4C, A_EXT = 8'h50,
        A_LSYNC = 8'h60;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [31:0] pins = '0;
    logic [31:0] pin_out, pin_oe;
    logic        irq;
    int          n_checks = 0;
    int          n_fails = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_port uut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pin_in(pins), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk); penable = 1'b1;
        @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        psel = 1'b1; pwrite = 1'b0; paddr = a;
        @(negedge clk); penable = 1'b1;
        #1 d = prdata;
        @(negedge clk); psel = 1'b0; penable = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bus_rd(a, v);
        check(req, v, exp);
    endtask

    task automatic t_reset;
        rd_chk("R1 dout", A_DOUT, 0);
        rd_chk("R1 dir", A_DIR, 0);
        rd_chk("R1 inten", A_INTEN, 0);
        rd_chk("R1 mask", A_MASK, 0);
        rd_chk("R1 type", A_TYPE, 0);
        rd_chk("R1 pol", A_POL, 0);
        rd_chk("R1 debounce", A_DEBNC, 0);
        rd_chk("R1 raw", A_RAW, 0);
        rd_chk("R1 stat", A_STAT, 0);
        check("R1 pins", {pin_out | pin_oe}, 0);
        check("R1 irq", {31'd0, irq}, 0);
    endtask

    task automatic t_out_dir;
        bus_wr(A_DOUT, 32'hA5A5_0F0F);
        bus_wr(A_DIR, 32'hFFFF_0000);
        check("R2 pin_out", pin_out, 32'hA5A5_0F0F);
        check("R2 pin_oe", pin_oe, 32'hFFFF_0000);
        rd_chk("R2 dout rb", A_DOUT, 32'hA5A5_0F0F);
        rd_chk("R2 dir rb", A_DIR, 32'hFFFF_0000);
        bus_wr(A_DIR, 0);
        bus_wr(A_DOUT, 0);
    endtask

    task automatic t_ext;
        pins = 32'h1234_5678;
        settle(3);
        rd_chk("R3 ext", A_EXT, 32'h1234_5678);
        pins = 32'h0;
        settle(3);
        rd_chk("R3 ext zero", A_EXT, 0);
    endtask

    task automatic t_level;
        bus_wr(A_TYPE, 0);
        bus_wr(A_POL, 32'h08);
        bus_wr(A_INTEN, 32'h28);
        settle(3);
        rd_chk("R4 low-active", A_RAW, 32'h20);
        pins = 32'h08; settle(3);
        rd_chk("R4 both active", A_RAW, 32'h28);
        pins = 32'h20; settle(3);
        rd_chk("R4 inactive clears", A_RAW, 0);
        pins = 0;
        bus_wr(A_INTEN, 0);
        bus_wr(A_POL, 0);
    endtask

    task automatic t_edge_eoi;
        logic [31:0] v;
        pins = 32'h4; settle(3);
        bus_wr(A_TYPE, 32'h6);
        bus_wr(A_POL, 32'h2);
        bus_wr(A_INTEN, 32'h6);
        rd_chk("R5 quiet", A_RAW, 0);
        pins = 32'h2; settle(3);
        rd_chk("R5 rise and fall", A_RAW, 32'h6);
        pins = 32'h4; settle(3);
        rd_chk("R5 sticky", A_RAW, 32'h6);
        bus_wr(A_EOI, 32'h2);
        rd_chk("R6 eoi one pin", A_RAW, 32'h4);
        bus_rd(A_EOI, v);
        check("R6 eoi reads 0", v, 0);
        bus_wr(A_EOI, 32'h0);
        rd_chk("R6 eoi zero no effect", A_RAW, 32'h4);
        bus_wr(A_EOI, 32'h4);
        rd_chk("R6 eoi cleared", A_RAW, 0);
        pins = 32'h6; settle(3);
        rd_chk("R5 rise only pin1", A_RAW, 32'h2);
        bus_wr(A_EOI, 32'h6);
        pins = 32'h4; settle(3);
        rd_chk("R5 opposite edge", A_RAW, 0);
        bus_wr(A_INTEN, 0);
        bus_wr(A_TYPE, 0);
        bus_wr(A_POL, 0);
        pins = 0; settle(3);
    endtask

    task automatic t_mask;
        bus_wr(A_POL, 32'h80);
        bus_wr(A_INTEN, 32'h80);
        pins = 32'h80; settle(3);
        rd_chk("R8 stat", A_STAT, 32'h80);
        check("R8 irq on", {31'd0, irq}, 1);
        bus_wr(A_MASK, 32'h80);
        rd_chk("R8 masked stat", A_STAT, 0);
        rd_chk("R8 raw kept", A_RAW, 32'h80);
        check("R8 irq off", {31'd0, irq}, 0);
        bus_wr(A_MASK, 0);
        bus_wr(A_INTEN, 0);
        bus_wr(A_POL, 0);
        pins = 0; settle(3);
    endtask

    task automatic t_enable;
        bus_wr(A_TYPE, 32'h200);
        bus_wr(A_POL, 32'h200);
        pins = 32'h200; settle(3);
        rd_chk("R7 disabled raw", A_RAW, 0);
        bus_wr(A_INTEN, 32'h200);
        rd_chk("R7 edge while disabled lost", A_RAW, 0);
        check("R7 irq", {31'd0, irq}, 0);
        pins = 0; settle(3);
        pins = 32'h200; settle(3);
        rd_chk("R7 enabled latches", A_RAW, 32'h200);
        bus_wr(A_EOI, 32'h200);
        bus_wr(A_INTEN, 0);
        bus_wr(A_TYPE, 0);
        bus_wr(A_POL, 0);
        pins = 0; settle(3);
    endtask

    task automatic t_dir;
        bus_wr(A_POL, 32'h400);
        bus_wr(A_DIR, 32'h400);
        bus_wr(A_INTEN, 32'h400);
        pins = 32'h400; settle(3);
        rd_chk("R9 output pin quiet", A_RAW, 0);
        check("R9 irq", {31'd0, irq}, 0);
        bus_wr(A_DIR, 0);
        rd_chk("R9 input pin active", A_RAW, 32'h400);
        bus_wr(A_INTEN, 0);
        bus_wr(A_POL, 0);
        pins = 0; settle(3);
    endtask

    task automatic t_ro;
        bus_wr(A_RAW, 32'hFFFF_FFFF);
        bus_wr(A_STAT, 32'hFFFF_FFFF);
        bus_wr(A_EXT, 32'hFFFF_FFFF);
        rd_chk("R10 raw ro", A_RAW, 0);
        rd_chk("R10 stat ro", A_STAT, 0);
        rd_chk("R10 ext ro", A_EXT, 0);
        check("R10 no side effect", pin_out | pin_oe, 0);
        bus_wr(A_DEBNC, 32'h0000_00F0);
        rd_chk("R10 debounce", A_DEBNC, 32'h0000_00F0);
        bus_wr(A_LSYNC, 32'hFFFF_FFFF);
        rd_chk("R10 lsync bit0", A_LSYNC, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_out_dir;
        t_ext;
        t_level;
        t_edge_eoi;
        t_mask;
        t_enable;
        t_dir;
        t_ro;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule